// File: doc/BRIEF.md
# LTC frame serializer with biphase-mark output

This block turns an eight-byte time code frame into a longitudinal time code line signal. The processor fills a staging buffer through a byte-wide write port. Each frame on the line is 80 bit cells long. Cells 0 to 63 carry the 64 frame bits and cells 64 to 79 carry a fixed 16-bit sync word. Every cell leaves the block biphase-mark encoded. A bit-rate clock enable, `half_tick`, pulses twice per cell. The first pulse of a cell marks its boundary and the second marks its middle.

The block holds frame data in two buffers. The processor writes the staging buffer. The serializer reads the output buffer. When the cell at index 72 of a frame starts, the staging buffer is copied into the output buffer, but only if transmission is enabled. The copy falls inside the sync word, so the frame bits being sent are never disturbed. The copy also sets a transmit interrupt flag, which stays set until it is acknowledged. The copy happens part way through frame N, so data written after the interrupt misses frame N+1 and first goes out in frame N+2.

The sequencer is a three-state machine:
- **IDLE**: the line is held and the cell counter is at zero.
- **DATA**: cells 0 to 63 are being sent.
- **SYNC**: cells 64 to 79 are being sent.

Its transitions are:
- **start**: IDLE to DATA, on a `half_tick` while `tx_en` is high.
- **enter_sync**: DATA to SYNC, at the boundary of cell 64.
- **next_frame**: SYNC to DATA, at a frame boundary while `tx_en` is high.
- **stop**: SYNC to IDLE, at a frame boundary while `tx_en` is low.

Top module: `ltc_frame_tx`

## Requirements
- R1: After reset, `line_out` is 0 and `tx_irq` is 0. The output buffer is all zero, so the first frame sent after enabling carries 64 zero data bits.
- R2: While the block is idle and `tx_en` is low, `line_out` does not change on `half_tick`. The first `half_tick` that arrives with `tx_en` high is the boundary of cell 0 of a new frame.
- R3: The two `half_tick` pulses of a cell are its boundary and then its middle. `line_out` toggles at every cell boundary. At mid-cell it toggles only when the cell's bit is 1, and it is otherwise held.
- R4: Frame cell k, for k from 0 to 63, carries bit (k mod 8) of output-buffer byte (k div 8). Byte 0 is sent first, and each byte is sent least significant bit first. Byte address n is written through `wr_addr` = n.
- R5: Cells 64 to 79 carry the sync pattern 0,0, then twelve 1s, then 0,1, in that order.
- R6: The bytes are sent unchanged, in this field layout:
  - The low nibbles of bytes 0 to 7 hold frame units, frames tens, seconds units, seconds tens, minutes units, minutes tens, hours units and hours tens.
  - The high nibbles hold user groups 1 to 8.
  - Byte 1: bits 1:0 are frames tens, bit 2 is drop-frame and bit 3 is colour-frame.
  - Byte 3: bits 2:0 are seconds tens and bit 3 is phase correction.
  - Byte 5: bits 2:0 are minutes tens and bit 3 is a group flag.
  - Byte 7: bits 1:0 are hours tens, bit 2 is unassigned and bit 3 is a group flag.
- R7: On the clock edge that starts cell 72, with `tx_en` high, the staging buffer is copied into the output buffer and `tx_irq` is set. `tx_irq` is visible high once the boundary `half_tick` of cell 72 has been taken.
- R8: Data written to the staging buffer before the copy in frame N is sent in frame N+1. Data written after that copy is not sent in frame N+1 and is sent in frame N+2.
- R9: If `tx_en` is low on the edge that starts cell 72, no copy takes place and `tx_irq` is not set. The next frame then repeats the previous output-buffer contents.
- R10: If `tx_en` falls mid-frame, the current frame still completes all 80 cells. After that the block returns to idle and holds the line.
- R11: `tx_irq` stays set until `irq_ack` is high on a clock edge. If a copy and `irq_ack` fall on the same edge, the copy wins and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Half-cell enable, two pulses per bit cell |
| tx_en | input | 1 | Transmission enable; gates the copy and frame start |
| wr_en | input | 1 | Staging buffer byte write strobe |
| wr_addr | input | 3 | Staging byte address |
| wr_data | input | 8 | Staging byte data |
| irq_ack | input | 1 | Clears the transmit interrupt flag |
| line_out | output | 1 | Biphase-mark encoded line level |
| tx_irq | output | 1 | Transmit interrupt flag |

## Verification
The bench decodes the line cell by cell and checks every frame bit, every time field and the sync word. A copy placed at the wrong cell would show up as a frame carrying staged data one frame too early or too late. The bench writes new data right after a copy. If the copy came at frame start or the buffer were single, that data would appear in frame N+1 instead of N+2. The bench lowers `tx_en` exactly around cell 72 and expects no copy and no flag. It also drops `tx_en` mid-frame and expects the frame to finish whole and the line to stay quiet. Finally, it acknowledges the flag on the same edge as a copy, and a flag lost in that case would show up as low.

// File: rtl/ltc_tx_pkg.sv
package ltc_tx_pkg;

    // Sync word, cell 64 carries bit 0 of this constant and cell 79 bit 15.
    localparam logic [15:0] LTC_SYNC_WORD = 16'hBFFC;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_SYNC = 2'd2
    } seq_state_t;

endpackage

// File: rtl/ltc_stage_regs.sv
module ltc_stage_regs #(
    parameter int NBYTES = 8,
    localparam int ADDR_W = $clog2(NBYTES),
    localparam int FLAT_W = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [FLAT_W-1:0] stage_flat
);

    // One byte register per frame byte, each decoding its own address.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] byte_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(b))) begin
                byte_q <= wr_data;
            end
        end

        assign stage_flat[b*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/ltc_xfer_unit.sv
module ltc_xfer_unit #(
    parameter int NBITS = 64,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             irq_ack,
    input  logic [NBITS-1:0] stage_flat,
    input  logic [IDX_W-1:0] data_idx,
    output logic             data_bit,
    output logic             irq_q
);

    logic [NBITS-1:0] out_q;

    // Output buffer: replaced whole on a copy, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (load) begin
            out_q <= stage_flat;
        end
    end

    // Interrupt flag: a copy takes priority over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (load) begin
            irq_q <= 1'b1;
        end else if (irq_ack) begin
            irq_q <= 1'b0;
        end
    end

    assign data_bit = out_q[data_idx];

    assert_copy_on_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (out_q == $past(stage_flat)));

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_ack) |=> irq_q);

    assert_buf_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(out_q));

endmodule

// File: rtl/ltc_cell_seq.sv
module ltc_cell_seq
    import ltc_tx_pkg::*;
#(
    parameter int DATA_BITS = 64,
    parameter int SYNC_BITS = 16,
    parameter int LOAD_CELL = 72,
    parameter logic [SYNC_BITS-1:0] SYNC_WORD = LTC_SYNC_WORD[SYNC_BITS-1:0],
    localparam int FRAME_BITS = DATA_BITS + SYNC_BITS,
    localparam int IDX_W = $clog2(FRAME_BITS),
    localparam int DIDX_W = $clog2(DATA_BITS),
    localparam int SIDX_W = $clog2(SYNC_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              tx_en,
    input  logic              data_bit,
    output logic [DIDX_W-1:0] data_idx,
    output logic              cell_start,
    output logic              cell_mid,
    output logic              cur_bit,
    output logic              load_req
);

    localparam logic [IDX_W-1:0] IDX_ZERO = '0;
    localparam logic [IDX_W-1:0] IDX_SYNC = IDX_W'(DATA_BITS);
    localparam logic [IDX_W-1:0] IDX_LOAD = IDX_W'(LOAD_CELL);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    seq_state_t state_q, state_nx;
    logic [IDX_W-1:0] next_idx_q;   // index of the next cell to start
    logic             mid_q;        // next tick is a mid-cell tick
    logic             boundary;
    logic             wrap_pt;
    logic             start_ok;
    logic             next_bit;
    logic [SIDX_W-1:0] sync_sel;

    assign boundary = half_tick && !mid_q;
    assign wrap_pt  = (next_idx_q == IDX_ZERO);
    assign start_ok = boundary && !(wrap_pt && !tx_en);

    // DATA_BITS is a multiple of SYNC_BITS, so the low bits index the sync word.
    assign data_idx = next_idx_q[DIDX_W-1:0];
    assign sync_sel = next_idx_q[SIDX_W-1:0];
    assign next_bit = (next_idx_q < IDX_SYNC) ? data_bit : SYNC_WORD[sync_sel];

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (boundary && (next_idx_q == IDX_SYNC)) state_nx = ST_SYNC;
            end
            ST_SYNC: begin
                if (boundary && wrap_pt) state_nx = tx_en ? ST_DATA : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        cell_start = 1'b0;
        cell_mid   = 1'b0;
        load_req   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cell_start = start_ok;
            end
            ST_DATA: begin
                cell_start = start_ok;
                cell_mid   = half_tick && mid_q;
            end
            ST_SYNC: begin
                cell_start = start_ok;
                cell_mid   = half_tick && mid_q;
                load_req   = start_ok && tx_en && (next_idx_q == IDX_LOAD);
            end
            default: begin
                cell_start = 1'b0;
            end
        endcase
    end

    // Cell counter, half-cell phase and latched cell bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_idx_q <= '0;
            mid_q      <= 1'b0;
            cur_bit    <= 1'b0;
        end else if (cell_start) begin
            cur_bit    <= next_bit;
            mid_q      <= 1'b1;
            next_idx_q <= (next_idx_q == IDX_LAST) ? IDX_ZERO : next_idx_q + 1'b1;
        end else if (cell_mid) begin
            mid_q      <= 1'b0;
        end
    end

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        next_idx_q <= IDX_LAST);

    assert_idle_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!mid_q && wrap_pt));

    assert_load_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> ((state_q == ST_SYNC) && (next_idx_q == IDX_LOAD + 1'b1)));

    assert_frame_completes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && !tx_en && boundary) |-> cell_start);

endmodule

// File: rtl/ltc_bpm_enc.sv
module ltc_bpm_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_start,
    input  logic cell_mid,
    input  logic cur_bit,
    output logic line_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else if (cell_start || (cell_mid && cur_bit)) begin
            line_q <= !line_q;
        end
    end

    assert_zero_mid_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_mid && !cur_bit) |=> $stable(line_q));

    assert_boundary_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cell_start |=> (line_q != $past(line_q)));

endmodule

// File: rtl/ltc_frame_tx.sv
module ltc_frame_tx
    import ltc_tx_pkg::*;
#(
    parameter int FRAME_BYTES = 8,
    parameter int SYNC_BITS = 16,
    parameter int LOAD_CELL = 72,
    localparam int DATA_BITS = FRAME_BYTES * 8,
    localparam int ADDR_W = $clog2(FRAME_BYTES),
    localparam int DIDX_W = $clog2(DATA_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              irq_ack,
    output logic              line_out,
    output logic              tx_irq
);

    logic [DATA_BITS-1:0] stage_flat;
    logic [DIDX_W-1:0]    data_idx;
    logic                 data_bit;
    logic                 cell_start;
    logic                 cell_mid;
    logic                 cur_bit;
    logic                 load_req;

    ltc_stage_regs #(.NBYTES(FRAME_BYTES)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .stage_flat(stage_flat)
    );

    ltc_xfer_unit #(.NBITS(DATA_BITS)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_req),
        .irq_ack   (irq_ack),
        .stage_flat(stage_flat),
        .data_idx  (data_idx),
        .data_bit  (data_bit),
        .irq_q     (tx_irq)
    );

    ltc_cell_seq #(
        .DATA_BITS(DATA_BITS),
        .SYNC_BITS(SYNC_BITS),
        .LOAD_CELL(LOAD_CELL),
        .SYNC_WORD(LTC_SYNC_WORD[SYNC_BITS-1:0])
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .tx_en     (tx_en),
        .data_bit  (data_bit),
        .data_idx  (data_idx),
        .cell_start(cell_start),
        .cell_mid  (cell_mid),
        .cur_bit   (cur_bit),
        .load_req  (load_req)
    );

    ltc_bpm_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_start(cell_start),
        .cell_mid  (cell_mid),
        .cur_bit   (cur_bit),
        .line_q    (line_out)
    );

    assert_line_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(line_out));

    assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !$rose(tx_irq));

endmodule

// File: tb/ltc_frame_tx_tb.sv
`timescale 1ns/1ps
module ltc_frame_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_ack = 1'b0;
    logic       line_out;
    logic       tx_irq;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = !clk;

    ltc_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .tx_en(tx_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_ack(irq_ack),
        .line_out(line_out), .tx_irq(tx_irq)
    );

    // Entry: {3'b0, bgf2, bgf1, phase, colour, drop, hours, minutes, seconds, frames, user32}
    localparam logic [71:0] VEC [4] = '{
        {3'b0, 5'b00001, 8'h23, 8'h59, 8'h59, 8'h29, 32'h1234_5678},
        {3'b0, 5'b11111, 8'h00, 8'h00, 8'h00, 8'h00, 32'hFFFF_FFFF},
        {3'b0, 5'b00100, 8'h12, 8'h34, 8'h56, 8'h07, 32'hA5A5_5A5A},
        {3'b0, 5'b00010, 8'h19, 8'h08, 8'h47, 8'h24, 32'h0000_0000}
    };
    localparam logic [15:0] SYNC_EXP = 16'hBFFC;

    function automatic logic [63:0] pack(input logic [71:0] e);
        logic [31:0] ub;
        ub = e[31:0];
        pack[7:0]   = {ub[3:0],   e[35:32]};
        pack[15:8]  = {ub[7:4],   e[65], e[64], e[37:36]};
        pack[23:16] = {ub[11:8],  e[43:40]};
        pack[31:24] = {ub[15:12], e[66], e[46:44]};
        pack[39:32] = {ub[19:16], e[51:48]};
        pack[47:40] = {ub[23:20], e[67], e[54:52]};
        pack[55:48] = {ub[27:24], e[59:56]};
        pack[63:56] = {ub[31:28], e[68], 1'b0, e[61:60]};
    endfunction

    function automatic logic [71:0] unpack(input logic [79:0] f);
        logic [71:0] e;
        e = '0;
        for (int i = 0; i < 8; i++) e[4*i +: 4] = f[8*i+4 +: 4];
        e[39:32] = {2'b0, f[9:8], f[3:0]};
        e[47:40] = {1'b0, f[26:24], f[19:16]};
        e[55:48] = {1'b0, f[42:40], f[35:32]};
        e[63:56] = {2'b0, f[57:56], f[51:48]};
        e[64] = f[10];
        e[65] = f[11];
        e[66] = f[27];
        e[67] = f[43];
        e[68] = f[59];
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input bit ack);
        @(negedge clk);
        half_tick = 1'b1;
        irq_ack = ack;
        @(negedge clk);
        half_tick = 1'b0;
        irq_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic write_frame(input logic [63:0] d);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = 3'(b);
            wr_data = d[8*b +: 8];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // en_mode: 0 normal, 1 tx_en low only at the cell 72 boundary, 2 tx_en low from cell 40 on
    task automatic recv_frame(input int en_mode, input bit ack72, input bit late_wr,
                              input logic [63:0] late_data, output logic [79:0] f,
                              output bit i71, output bit i72, output int berr);
        logic pre;
        berr = 0;
        f = '0;
        i71 = 1'b0;
        i72 = 1'b0;
        for (int c = 0; c < 80; c++) begin
            if (en_mode == 1 && c == 72) tx_en = 1'b0;
            if (en_mode == 2 && c == 40) tx_en = 1'b0;
            pre = line_out;
            tick(ack72 && c == 72);
            if (line_out == pre) berr++;
            if (en_mode == 1 && c == 72) tx_en = 1'b1;
            if (c == 71) i71 = tx_irq;
            if (c == 72) i72 = tx_irq;
            if (late_wr && c == 72) write_frame(late_data);
            pre = line_out;
            tick(1'b0);
            f[c] = (line_out != pre);
        end
    endtask

    task automatic std_checks(input string tag, input logic [79:0] f, input int berr,
                              input logic [63:0] exp_data);
        check(f[63:0] == exp_data, "R4", {tag, " data bits"}, 80'(f[63:0]), 80'(exp_data));
        check(f[79:64] == SYNC_EXP, "R5", {tag, " sync word"}, 80'(f[79:64]), 80'(SYNC_EXP));
        check(berr == 0, "R3", {tag, " boundary toggles"}, 80'(berr), 80'(0));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [79:0] f;
        bit i71, i72;
        int berr;
        logic pre;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(line_out == 1'b0, "R1", "line after reset", 80'(line_out), 80'(0));
        check(tx_irq == 1'b0, "R1", "irq after reset", 80'(tx_irq), 80'(0));

        // R2: idle ticks with tx_en low leave the line alone
        pre = line_out;
        for (int k = 0; k < 4; k++) tick(1'b0);
        check(line_out == pre, "R2", "idle line", 80'(line_out), 80'(pre));
        check(tx_irq == 1'b0, "R2", "idle irq", 80'(tx_irq), 80'(0));

        write_frame(pack(VEC[0]));
        tx_en = 1'b1;
        recv_frame(0, 1'b0, 1'b0, '0, f, i71, i72, berr);
        std_checks("R1 first frame zero", f, berr, 64'h0);
        check(i71 == 1'b0, "R7", "irq before cell 72", 80'(i71), 80'(0));
        check(i72 == 1'b1, "R7", "irq at cell 72", 80'(i72), 80'(1));

        // Vector table walk: each staged entry appears in the following frame.
        for (int i = 1; i < 4; i++) begin
            ack_irq();
            write_frame(pack(VEC[i]));
            recv_frame(0, 1'b0, 1'b0, '0, f, i71, i72, berr);
            std_checks("R8 table frame", f, berr, pack(VEC[i-1]));
            check(unpack(f) == VEC[i-1], "R6", "decoded fields", 80'(unpack(f)), 80'(VEC[i-1]));
            check(i71 == 1'b0, "R7", "irq before cell 72", 80'(i71), 80'(0));
            check(i72 == 1'b1, "R7", "irq at cell 72", 80'(i72), 80'(1));
        end

        // R11: flag holds until acknowledged
        repeat (10) @(negedge clk);
        check(tx_irq == 1'b1, "R11", "irq held", 80'(tx_irq), 80'(1));
        ack_irq();
        @(negedge clk);
        check(tx_irq == 1'b0, "R11", "irq cleared", 80'(tx_irq), 80'(0));

        // R8: write just after the copy in frame N
        recv_frame(0, 1'b0, 1'b1, pack(VEC[0]), f, i71, i72, berr);
        std_checks("R8 frame N", f, berr, pack(VEC[3]));
        ack_irq();
        recv_frame(0, 1'b0, 1'b0, '0, f, i71, i72, berr);
        check(f[63:0] == pack(VEC[3]), "R8", "frame N+1 keeps old data",
              80'(f[63:0]), 80'(pack(VEC[3])));
        ack_irq();
        recv_frame(0, 1'b1, 1'b0, '0, f, i71, i72, berr);
        check(f[63:0] == pack(VEC[0]), "R8", "frame N+2 carries late write",
              80'(f[63:0]), 80'(pack(VEC[0])));
        check(i72 == 1'b1, "R11", "copy wins over same-edge ack", 80'(i72), 80'(1));

        // R9: tx_en low at cell 72 blocks the copy
        write_frame(pack(VEC[2]));
        ack_irq();
        recv_frame(1, 1'b0, 1'b0, '0, f, i71, i72, berr);
        std_checks("R9 gated frame", f, berr, pack(VEC[0]));
        check(i72 == 1'b0, "R9", "no irq without enable", 80'(i72), 80'(0));

        // R10: tx_en drops mid-frame, frame completes, then idle
        recv_frame(2, 1'b0, 1'b0, '0, f, i71, i72, berr);
        std_checks("R10 completing frame", f, berr, pack(VEC[0]));
        check(i72 == 1'b0, "R9", "no irq while disabled", 80'(i72), 80'(0));
        pre = line_out;
        for (int k = 0; k < 6; k++) tick(1'b0);
        check(line_out == pre, "R10", "line quiet after stop", 80'(line_out), 80'(pre));

        tx_en = 1'b1;
        ack_irq();
        recv_frame(0, 1'b0, 1'b0, '0, f, i71, i72, berr);
        std_checks("R9 repeat after no copy", f, berr, pack(VEC[0]));
        check(i72 == 1'b1, "R7", "copy resumes", 80'(i72), 80'(1));
        recv_frame(0, 1'b0, 1'b0, '0, f, i71, i72, berr);
        std_checks("R8 staged data arrives", f, berr, pack(VEC[2]));
        check(unpack(f) == VEC[2], "R6", "decoded fields", 80'(unpack(f)), 80'(VEC[2]));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule